// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms the memory address for a load or store operand from up to three terms: a base register, an index register shifted left by a scale of 1, 2, 4 or 8, and a displacement that is absent, a short signed byte, or a full word. Each term can be switched on or off on its own, so the block covers every mix from a lone displacement to base plus scaled index plus displacement. The sum wraps modulo 2^ADDR_W.

Register values come from an external register file through two combinational read ports. Port A is addressed by the base select and port B by the index select. The selects are passed straight through, and the data is expected back in the same cycle. One register number, the stack pointer (number 4 by default), may serve as a base but never as an index. Using it as an index raises an illegal flag and drops the index term. The reserved displacement size code does the same for the displacement term. The result and the flag are registered and appear one cycle after a valid request.

Top module: `agu_ea`

## Requirements
- R1: While reset is held, and after it is released until the first valid request, `out_valid`, `ea` and `illegal` are all 0. `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` high.
- R2: `rd_a_sel` equals `base_sel` and `rd_b_sel` equals `idx_sel` in the same cycle, with no register in the path.
- R3: `ea` = (`base_en` ? register[`base_sel`] : 0) + (legal index ? register[`idx_sel`] scaled : 0) + displacement term. The sum is taken modulo 2^32.
- R4: `scale` codes 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8 (a left shift by the code).
- R5: `disp_size` code 0 adds nothing. Code 1 adds `disp[7:0]` sign-extended to 32 bits, and `disp[31:8]` has no effect. Code 2 adds all 32 bits of `disp`.
- R6: The stack pointer register (number 4) is accepted as the base without raising `illegal`.
- R7: `idx_en`=1 with `idx_sel`=4 sets `illegal` to 1 and leaves the index term out of `ea`.
- R8: `disp_size` code 3 is reserved. It sets `illegal` to 1 and leaves the displacement term out of `ea`.
- R9: In a cycle after `in_valid` was low, `ea` and `illegal` keep their previous values and `out_valid` is 0, whatever the other inputs did.
- R10: `illegal` is 0 for every request that triggers neither R7 nor R8. This includes `idx_sel`=4 with `idx_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| base_en | input | 1 | Include the base register term |
| base_sel | input | 3 | Base register number |
| idx_en | input | 1 | Include the scaled index term |
| idx_sel | input | 3 | Index register number |
| scale | input | 2 | Index shift code (x1, x2, x4, x8) |
| disp_size | input | 2 | 0 none, 1 byte sign-extended, 2 word, 3 reserved |
| disp | input | 32 | Displacement value |
| rd_a_sel | output | 3 | Register file read port A address (base) |
| rd_a_data | input | 32 | Register file read port A data |
| rd_b_sel | output | 3 | Register file read port B address (index) |
| rd_b_data | input | 32 | Register file read port B data |
| out_valid | output | 1 | Result present this cycle |
| ea | output | 32 | Effective address |
| illegal | output | 1 | Request used a forbidden encoding |

## Verification
The read selects are combinational and are due in the request cycle itself. The bench checks them shortly after driving the inputs, before any clock edge. `ea`, `illegal` and `out_valid` pass through one register, so they are due after the first rising edge following the request. Stimulus is applied on a falling edge and the registered outputs are sampled on the next falling edge, half a period clear of the capture edge. The hold behaviour is checked one falling edge after a cycle with no request, once the other inputs have been scrambled.

// File: rtl/agu_pkg.sv
package agu_pkg;
   typedef enum logic [1:0] {
      DSZ_NONE   = 2'd0,
      DSZ_NARROW = 2'd1,
      DSZ_WIDE   = 2'd2,
      DSZ_RSVD   = 2'd3
   } dsz_e;
endpackage

// File: rtl/agu_disp_ext.sv
module agu_disp_ext #(
   parameter int ADDR_W   = 32,
   parameter int NARROW_W = 8
) (
   input  logic [1:0]        size_code,
   input  logic [ADDR_W-1:0] raw,
   output logic [ADDR_W-1:0] term,
   output logic              bad
);
   import agu_pkg::*;

   logic [ADDR_W-1:0] narrow_x;

   generate
      if (NARROW_W < ADDR_W) begin : g_sext
         assign narrow_x = {{(ADDR_W-NARROW_W){raw[NARROW_W-1]}}, raw[NARROW_W-1:0]};
      end else begin : g_pass
         assign narrow_x = raw;
      end
   endgenerate

   always_comb begin
      bad  = 1'b0;
      term = '0;
      case (dsz_e'(size_code))
         DSZ_NONE:   term = '0;
         DSZ_NARROW: term = narrow_x;
         DSZ_WIDE:   term = raw;
         default: begin
            term = '0;
            bad  = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/agu_scaler.sv
module agu_scaler #(
   parameter int ADDR_W  = 32,
   parameter int SCALE_W = 2
) (
   input  logic [ADDR_W-1:0]  val,
   input  logic [SCALE_W-1:0] code,
   input  logic               use_it,
   output logic [ADDR_W-1:0]  term
);
   localparam int NSHIFT = 1 << SCALE_W;

   logic [ADDR_W-1:0] shifted [NSHIFT];

   generate
      for (genvar k = 0; k < NSHIFT; k++) begin : g_shift
         assign shifted[k] = val << k;
      end
   endgenerate

   assign term = use_it ? shifted[code] : '0;
endmodule

// File: rtl/agu_sum3.sv
module agu_sum3 #(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] a,
   input  logic [ADDR_W-1:0] b,
   input  logic [ADDR_W-1:0] c,
   output logic [ADDR_W-1:0] sum
);
   assign sum = a + b + c;
endmodule

// File: rtl/agu_ea.sv
module agu_ea #(
   parameter int ADDR_W   = 32,
   parameter int NREG     = 8,
   parameter int SP_IDX   = 4,
   parameter int NARROW_W = 8,
   parameter int SCALE_W  = 2,
   localparam int SEL_W   = $clog2(NREG)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic                base_en,
   input  logic [SEL_W-1:0]    base_sel,
   input  logic                idx_en,
   input  logic [SEL_W-1:0]    idx_sel,
   input  logic [SCALE_W-1:0]  scale,
   input  logic [1:0]          disp_size,
   input  logic [ADDR_W-1:0]   disp,
   output logic [SEL_W-1:0]    rd_a_sel,
   input  logic [ADDR_W-1:0]   rd_a_data,
   output logic [SEL_W-1:0]    rd_b_sel,
   input  logic [ADDR_W-1:0]   rd_b_data,
   output logic                out_valid,
   output logic [ADDR_W-1:0]   ea,
   output logic                illegal
);
   localparam logic [SEL_W-1:0] SP_SEL = SEL_W'(SP_IDX);

   initial begin
      assert (NREG >= 2 && (1 << SEL_W) == NREG)
         else $error("agu_ea: NREG must be a power of two");
      assert (SP_IDX >= 0 && SP_IDX < NREG)
         else $error("agu_ea: SP_IDX out of range");
      assert (NARROW_W >= 1 && NARROW_W <= ADDR_W)
         else $error("agu_ea: NARROW_W out of range");
      assert ((1 << SCALE_W) <= ADDR_W)
         else $error("agu_ea: SCALE_W too large");
   end

   // Read port addressing: straight through
   assign rd_a_sel = base_sel;
   assign rd_b_sel = idx_sel;

   logic              idx_is_sp;
   logic              idx_use;
   logic [ADDR_W-1:0] base_term;
   logic [ADDR_W-1:0] idx_term;
   logic [ADDR_W-1:0] disp_term;
   logic              disp_bad;
   logic [ADDR_W-1:0] ea_next;

   assign idx_is_sp = idx_en && (idx_sel == SP_SEL);
   assign idx_use   = idx_en && !idx_is_sp;
   assign base_term = base_en ? rd_a_data : '0;

   agu_scaler #(.ADDR_W(ADDR_W), .SCALE_W(SCALE_W)) u_scale (
      .val    (rd_b_data),
      .code   (scale),
      .use_it (idx_use),
      .term   (idx_term)
   );

   agu_disp_ext #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) u_disp (
      .size_code (disp_size),
      .raw       (disp),
      .term      (disp_term),
      .bad       (disp_bad)
   );

   agu_sum3 #(.ADDR_W(ADDR_W)) u_sum (
      .a   (base_term),
      .b   (idx_term),
      .c   (disp_term),
      .sum (ea_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         ea        <= '0;
         illegal   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            ea      <= ea_next;
            illegal <= idx_is_sp || disp_bad;
         end
      end
   end
endmodule

// File: rtl/agu_ea_chk.sv
module agu_ea_chk #(
   parameter int ADDR_W   = 32,
   parameter int NREG     = 8,
   parameter int SP_IDX   = 4,
   parameter int NARROW_W = 8,
   parameter int SCALE_W  = 2,
   localparam int SEL_W   = $clog2(NREG)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic               base_en,
   input logic [SEL_W-1:0]   base_sel,
   input logic               idx_en,
   input logic [SEL_W-1:0]   idx_sel,
   input logic [1:0]         disp_size,
   input logic [ADDR_W-1:0]  disp,
   input logic [SEL_W-1:0]   rd_a_sel,
   input logic [ADDR_W-1:0]  rd_a_data,
   input logic [SEL_W-1:0]   rd_b_sel,
   input logic               out_valid,
   input logic [ADDR_W-1:0]  ea,
   input logic               illegal
);
   localparam logic [SEL_W-1:0] SP_SEL = SEL_W'(SP_IDX);

   // R1
   a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r1_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R2
   always_comb begin
      if (rst_n) begin
         a_r2_port_sel: assert (rd_a_sel == base_sel && rd_b_sel == idx_sel);
      end
   end

   // R7
   a_r7_sp_index_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && idx_en && idx_sel == SP_SEL) |=> illegal);

   // R8
   a_r8_rsvd_disp_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && disp_size == 2'd3) |=> illegal);

   // R6, R3
   a_r6_base_only: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && base_en && !idx_en && disp_size == 2'd0)
      |=> (ea == $past(rd_a_data) && !illegal));

   // R5
   a_r5_narrow_only: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !base_en && !idx_en && disp_size == 2'd1)
      |=> ea == ADDR_W'($signed($past(disp[NARROW_W-1:0]))));

   // R9
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(ea) && $stable(illegal)));
endmodule

bind agu_ea agu_ea_chk #(
   .ADDR_W(ADDR_W), .NREG(NREG), .SP_IDX(SP_IDX),
   .NARROW_W(NARROW_W), .SCALE_W(SCALE_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
   .base_en(base_en), .base_sel(base_sel),
   .idx_en(idx_en), .idx_sel(idx_sel),
   .disp_size(disp_size), .disp(disp),
   .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data), .rd_b_sel(rd_b_sel),
   .out_valid(out_valid), .ea(ea), .illegal(illegal)
);

// File: tb/tb_agu_ea.sv
module tb_agu_ea;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        base_en = 1'b0;
   logic [2:0]  base_sel = '0;
   logic        idx_en = 1'b0;
   logic [2:0]  idx_sel = '0;
   logic [1:0]  scale = '0;
   logic [1:0]  disp_size = '0;
   logic [31:0] disp = '0;
   logic [2:0]  rd_a_sel;
   logic [2:0]  rd_b_sel;
   logic [31:0] rd_a_data;
   logic [31:0] rd_b_data;
   logic        out_valid;
   logic [31:0] ea;
   logic        illegal;

   logic [31:0] regs [8];

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign rd_a_data = regs[rd_a_sel];
   assign rd_b_data = regs[rd_b_sel];

   agu_ea dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .base_en(base_en), .base_sel(base_sel),
      .idx_en(idx_en), .idx_sel(idx_sel),
      .scale(scale), .disp_size(disp_size), .disp(disp),
      .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
      .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
      .out_valid(out_valid), .ea(ea), .illegal(illegal)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] model_ea(input logic be, input logic [2:0] bs,
         input logic ie, input logic [2:0] is, input logic [1:0] sc,
         input logic [1:0] dz, input logic [31:0] d);
      logic [31:0] s;
      s = '0;
      if (be) s = s + regs[bs];
      if (ie && is != 3'd4) s = s + (regs[is] << sc);
      if (dz == 2'd1) s = s + {{24{d[7]}}, d[7:0]};
      else if (dz == 2'd2) s = s + d;
      return s;
   endfunction

   function automatic logic model_ill(input logic ie, input logic [2:0] is, input logic [1:0] dz);
      return (ie && is == 3'd4) || dz == 2'd3;
   endfunction

   // Called at a falling edge; returns at the next falling edge after checking.
   task automatic do_op(input string tag, input logic be, input logic [2:0] bs,
         input logic ie, input logic [2:0] is, input logic [1:0] sc,
         input logic [1:0] dz, input logic [31:0] d);
      logic [31:0] e_ea;
      logic        e_ill;
      in_valid = 1'b1; base_en = be; base_sel = bs; idx_en = ie; idx_sel = is;
      scale = sc; disp_size = dz; disp = d;
      e_ea  = model_ea(be, bs, ie, is, sc, dz, d);
      e_ill = model_ill(ie, is, dz);
      #1;
      check({tag, " R2 port A select"}, 32'(rd_a_sel), 32'(bs));
      check({tag, " R2 port B select"}, 32'(rd_b_sel), 32'(is));
      @(negedge clk);
      in_valid = 1'b0;
      check({tag, " R1 out_valid"}, 32'(out_valid), 32'd1);
      check({tag, " R3 ea"}, ea, e_ea);
      check({tag, " R10 illegal"}, 32'(illegal), 32'(e_ill));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] held_ea;
      logic        held_ill;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 8; i++) regs[i] = $urandom();

      // R1 reset state
      repeat (3) @(negedge clk);
      check("R1 reset out_valid", 32'(out_valid), 32'd0);
      check("R1 reset ea", ea, 32'd0);
      check("R1 reset illegal", 32'(illegal), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle after reset out_valid", 32'(out_valid), 32'd0);
      check("R1 idle after reset ea", ea, 32'd0);

      // Directed corners
      regs[4] = 32'h0000_8000;
      regs[3] = 32'hFFFF_FFF0;
      regs[5] = 32'h1000_0000;
      do_op("R6 stack pointer as base", 1, 3'd4, 0, 3'd0, 2'd0, 2'd0, 32'h0);
      check("R6 ea equals SP", ea, 32'h0000_8000);
      do_op("R7 stack pointer as index", 1, 3'd5, 1, 3'd4, 2'd3, 2'd0, 32'h0);
      check("R7 flag", 32'(illegal), 32'd1);
      check("R7 index dropped", ea, 32'h1000_0000);
      do_op("R10 SP select with index off", 0, 3'd0, 0, 3'd4, 2'd2, 2'd0, 32'h0);
      check("R10 no flag", 32'(illegal), 32'd0);
      do_op("R5 narrow negative", 0, 3'd0, 0, 3'd0, 2'd0, 2'd1, 32'hABCD_EF80);
      check("R5 narrow sign-extended", ea, 32'hFFFF_FF80);
      do_op("R5 narrow positive", 0, 3'd0, 0, 3'd0, 2'd0, 2'd1, 32'hFFFF_FF7F);
      check("R5 narrow upper ignored", ea, 32'h0000_007F);
      do_op("R5 wide", 0, 3'd0, 0, 3'd0, 2'd0, 2'd2, 32'hDEAD_BEEF);
      check("R5 wide value", ea, 32'hDEAD_BEEF);
      do_op("R8 reserved size", 1, 3'd5, 0, 3'd0, 2'd0, 2'd3, 32'h1234_5678);
      check("R8 flag", 32'(illegal), 32'd1);
      check("R8 disp dropped", ea, 32'h1000_0000);
      do_op("R4 scale x8 wrap", 1, 3'd5, 1, 3'd3, 2'd3, 2'd1, 32'h0000_0004);
      check("R4 x8 wraps", ea, 32'h1000_0000 + 32'hFFFF_FF80 + 32'd4);
      for (int sc = 0; sc < 4; sc++) begin
         do_op("R4 scale sweep", 0, 3'd0, 1, 3'd5, 2'(sc), 2'd0, 32'h0);
         check("R4 scale value", ea, 32'h1000_0000 << sc);
      end
      do_op("R3 base+index+4", 1, 3'd3, 1, 3'd5, 2'd0, 2'd1, 32'h0000_0004);
      check("R3 all terms", ea, 32'h0FFF_FFF4);
      do_op("R3 nothing enabled", 0, 3'd7, 0, 3'd7, 2'd1, 2'd0, 32'hFFFF_FFFF);
      check("R3 zero address", ea, 32'd0);

      // R9 hold: scramble inputs with in_valid low
      held_ea  = ea;
      held_ill = illegal;
      base_en = 1; base_sel = 3'd2; idx_en = 1; idx_sel = 3'd4; disp_size = 2'd3;
      disp = 32'h5555_5555;
      @(negedge clk);
      check("R9 out_valid low", 32'(out_valid), 32'd0);
      check("R9 ea held", ea, held_ea);
      check("R9 illegal held", 32'(illegal), 32'(held_ill));

      // Constrained random
      for (int n = 0; n < 400; n++) begin
         if (n % 25 == 0) for (int i = 0; i < 8; i++) regs[i] = $urandom();
         do_op("R3 random", 1'($urandom()), 3'($urandom()), 1'($urandom()),
               3'($urandom()), 2'($urandom()), 2'($urandom()), $urandom());
         if ($urandom_range(0, 3) == 0) begin
            held_ea  = ea;
            held_ill = illegal;
            disp = $urandom(); base_sel = 3'($urandom());
            @(negedge clk);
            check("R9 random hold ea", ea, held_ea);
            check("R9 random hold illegal", 32'(illegal), 32'(held_ill));
            check("R1 random idle valid", 32'(out_valid), 32'd0);
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule